// File: doc/BRIEF.md
# Timer Output Compare Unit with Master-Channel Override

This block is an eight-channel output-compare timer. A 16-bit free-running counter advances on each cycle that the timer enable is high. Each channel owns a compare register. When the counter steps onto a channel's compare value, that channel applies its configured action to its own output pin: none, toggle, clear or set. An overflow of the counter can also toggle selected pins.

Channel 7 acts as the master channel. Its event is either its own compare match or a counter overflow while its overflow bit is set. When that event occurs, a mask register picks a group of pins and a data register gives each picked pin its new level. For the picked pins this override beats any compare action of channels 0 to 6 in the same cycle. A pin changes only while it is selected for output compare and not disconnected.

Software reaches every setting through a small register bus. A parameter can leave out the master channel. When it is left out, the mask and data registers become reserved.

Top module: `timer_oc`

## Requirements
- R1: Reset clears the counter to 0x0000. The counter adds one on each clock where `tmr_en` is 1 and holds otherwise. After 0xFFFF it wraps to 0x0000, and that step is the overflow.
- R2: Channel i matches on a clock where `tmr_en` is 1 and the incremented counter value equals compare register i. The pin update lands on the same edge that moves the counter onto that value. Pins do not change on a clock with no match, no overflow action and no master event.
- R3: Channels 0–6 use a 2-bit action code. 00 leaves the pin alone, 01 toggles it, 10 drives it to 0 and 11 drives it to 1. Channels 0–3 take bits [1:0],[3:2],[5:4],[7:6] at address 0xD. Channels 4–6 take bits [1:0],[3:2],[5:4] at address 0xE.
- R4: On overflow, each pin 0–6 whose bit is set at address 0xA toggles. A compare action on that channel in the same cycle takes precedence over the toggle.
- R5: The master event is a channel 7 compare match, or an overflow while bit 7 at address 0xA is set.
- R6: On a master event, every pin whose bit is set in the mask register (0xB) takes the matching bit of the data register (0xC).
- R7: Pins whose mask bit is clear are not changed by a master event. Their own compare and overflow actions still apply.
- R8: For a masked pin, the master event overrides a channel 0–6 compare action that occurs in the same cycle.
- R9: A pin can change only when its select bit (0x8) is 1 and its disconnect bit (0x9) is 0. Otherwise it holds its level.
- R10: Registers read back at any time. Compare registers 0–7 sit at 0x0–0x7 and use 16 bits. Registers 0x8–0xC use bits [7:0]. 0xD uses [7:0]. 0xE uses [5:0]. Unused bits and 0xF read as zero, and writes to 0xF are ignored.
- R11: When the master channel is left out (`HAS_MASTER`=0), writes to 0xB and 0xC have no effect, those addresses read zero, and no master event occurs.
- R12: After reset every register reads zero and all pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer enable; the counter advances while high |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| oc_pin | output | 8 | Output-compare pin levels |

## Verification
Two functions can land on the same edge. In one case, the master event and a lower channel's compare act on the same pin. In the other, the overflow toggle and a channel's own compare hit the same pin. The bench provokes the first by giving channels 0, 3 and 7 the same compare value, with pin 0 masked and pin 3 unmasked. It then checks that pin 0 shows the data bit instead of the toggled value, while pin 3 still takes its own set action. It provokes the second by running the counter to overflow with channel 3 set to match at 0x0000 and its overflow bit set, and it expects the set level rather than the toggle. A second instance without the master channel sees the same collision, which shows what the pins would have done with no override.

// File: rtl/timer_oc_pkg.sv
`timescale 1ns/1ps
package timer_oc_pkg;
    localparam int NCH    = 8;
    localparam int DW     = 16;
    localparam int AW     = 4;
    localparam int LOWCH  = NCH - 1;
    localparam int ACT_W  = 2 * LOWCH;

    localparam logic [AW-1:0] A_SEL   = 4'h8;
    localparam logic [AW-1:0] A_DIS   = 4'h9;
    localparam logic [AW-1:0] A_TOV   = 4'hA;
    localparam logic [AW-1:0] A_MASK  = 4'hB;
    localparam logic [AW-1:0] A_DATA  = 4'hC;
    localparam logic [AW-1:0] A_ACTLO = 4'hD;
    localparam logic [AW-1:0] A_ACTHI = 4'hE;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } oc_act_e;

    typedef struct packed {
        logic [NCH-1:0]   sel;
        logic [NCH-1:0]   dis;
        logic [NCH-1:0]   tov;
        logic [NCH-1:0]   mask;
        logic [NCH-1:0]   data;
        logic [ACT_W-1:0] act;
    } oc_cfg_t;

    function automatic logic apply_act(oc_act_e a, logic cur);
        case (a)
            ACT_TOGGLE: return ~cur;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return cur;
        endcase
    endfunction
endpackage

// File: rtl/oc_counter.sv
`timescale 1ns/1ps
module oc_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nx,
    output logic          ovf
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cst_t;

    cst_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        cnt_nx = st_q.cnt + CW'(1);
        if (tick) st_d.cnt = cnt_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = tick & (&st_q.cnt);
endmodule

// File: rtl/oc_regs.sv
`timescale 1ns/1ps
module oc_regs
    import timer_oc_pkg::*;
#(
    parameter int CW         = 16,
    parameter bit HAS_MASTER = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    input  logic                   wr,
    output logic [DW-1:0]          rdata,
    output oc_cfg_t                cfg,
    output logic [NCH-1:0][CW-1:0] cmp
);
    localparam int IDX_W = $clog2(NCH);
    localparam int HI_W  = ACT_W - 8;

    typedef struct packed {
        logic [NCH-1:0][CW-1:0] cmp;
        oc_cfg_t                cfg;
    } rst_t;

    rst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (!addr[AW-1]) begin
                st_d.cmp[addr[IDX_W-1:0]] = wdata[CW-1:0];
            end else begin
                case (addr)
                    A_SEL:   st_d.cfg.sel = wdata[NCH-1:0];
                    A_DIS:   st_d.cfg.dis = wdata[NCH-1:0];
                    A_TOV:   st_d.cfg.tov = wdata[NCH-1:0];
                    A_MASK:  if (HAS_MASTER) st_d.cfg.mask = wdata[NCH-1:0];
                    A_DATA:  if (HAS_MASTER) st_d.cfg.data = wdata[NCH-1:0];
                    A_ACTLO: st_d.cfg.act[7:0] = wdata[7:0];
                    A_ACTHI: st_d.cfg.act[ACT_W-1:8] = wdata[HI_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!addr[AW-1]) begin
            rdata = DW'(st_q.cmp[addr[IDX_W-1:0]]);
        end else begin
            case (addr)
                A_SEL:   rdata = DW'(st_q.cfg.sel);
                A_DIS:   rdata = DW'(st_q.cfg.dis);
                A_TOV:   rdata = DW'(st_q.cfg.tov);
                A_MASK:  rdata = DW'(st_q.cfg.mask);
                A_DATA:  rdata = DW'(st_q.cfg.data);
                A_ACTLO: rdata = DW'(st_q.cfg.act[7:0]);
                A_ACTHI: rdata = DW'(st_q.cfg.act[ACT_W-1:8]);
                default: rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;
    assign cmp = st_q.cmp;
endmodule

// File: rtl/oc_match.sv
`timescale 1ns/1ps
module oc_match
    import timer_oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                   tick,
    input  logic [CW-1:0]          cnt_nx,
    input  logic [NCH-1:0][CW-1:0] cmp,
    output logic [NCH-1:0]         match
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign match[g] = tick && (cnt_nx == cmp[g]);
    end
endmodule

// File: rtl/oc_pins.sv
`timescale 1ns/1ps
module oc_pins
    import timer_oc_pkg::*;
#(
    parameter bit HAS_MASTER = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] match,
    input  logic           ovf,
    input  oc_cfg_t        cfg,
    output logic [NCH-1:0] pins,
    output logic [NCH-1:0] conn,
    output logic           ev7
);
    typedef struct packed {
        logic [NCH-1:0] pin;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        logic nxt;
        st_d = st_q;
        conn = cfg.sel & ~cfg.dis;
        ev7  = HAS_MASTER && (match[NCH-1] || (ovf && cfg.tov[NCH-1]));
        for (int i = 0; i < LOWCH; i++) begin
            nxt = st_q.pin[i];
            if (ovf && cfg.tov[i]) nxt = ~st_q.pin[i];
            if (match[i])          nxt = apply_act(oc_act_e'(cfg.act[2*i +: 2]), st_q.pin[i]);
            if (ev7 && cfg.mask[i]) nxt = cfg.data[i];
            if (conn[i])           st_d.pin[i] = nxt;
        end
        if (ev7 && cfg.mask[NCH-1] && conn[NCH-1]) st_d.pin[NCH-1] = cfg.data[NCH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pins = st_q.pin;
endmodule

// File: rtl/timer_oc.sv
`timescale 1ns/1ps
module timer_oc
    import timer_oc_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter bit HAS_MASTER = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tmr_en,
    input  logic [3:0]    bus_addr,
    input  logic [15:0]   bus_wdata,
    input  logic          bus_wr,
    output logic [15:0]   bus_rdata,
    output logic [7:0]    oc_pin
);
    logic [CNT_W-1:0]          cnt_w;
    logic [CNT_W-1:0]          cnt_nx_w;
    logic                      ovf_w;
    logic [NCH-1:0][CNT_W-1:0] cmp_w;
    logic [NCH-1:0]            match_w;
    logic [NCH-1:0]            conn_w;
    logic                      ev7_w;
    oc_cfg_t                   cfg_w;

    oc_counter #(.CW(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tmr_en),
        .cnt    (cnt_w),
        .cnt_nx (cnt_nx_w),
        .ovf    (ovf_w)
    );

    oc_regs #(.CW(CNT_W), .HAS_MASTER(HAS_MASTER)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .wr    (bus_wr),
        .rdata (bus_rdata),
        .cfg   (cfg_w),
        .cmp   (cmp_w)
    );

    oc_match #(.CW(CNT_W)) u_match (
        .tick   (tmr_en),
        .cnt_nx (cnt_nx_w),
        .cmp    (cmp_w),
        .match  (match_w)
    );

    oc_pins #(.HAS_MASTER(HAS_MASTER)) u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .match (match_w),
        .ovf   (ovf_w),
        .cfg   (cfg_w),
        .pins  (oc_pin),
        .conn  (conn_w),
        .ev7   (ev7_w)
    );
endmodule

// File: rtl/timer_oc_chk.sv
`timescale 1ns/1ps
module timer_oc_chk
    import timer_oc_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter bit HAS_MASTER = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_en,
    input logic [CNT_W-1:0] cnt,
    input logic [NCH-1:0]   match,
    input logic             ovf,
    input logic             ev7,
    input logic [NCH-1:0]   conn,
    input oc_cfg_t          cfg,
    input logic [3:0]       addr,
    input logic [15:0]      rdata,
    input logic [NCH-1:0]   pins
);
    logic any_evt;
    assign any_evt = ev7 | (|match) | (ovf & (|cfg.tov));

    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_en |=> (CNT_W'(cnt - $past(cnt)) == CNT_W'(1)));

    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> $stable(cnt));

    p_quiet_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_evt |=> $stable(pins));

    p_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev7 |=> (((pins ^ $past(cfg.data)) & $past(cfg.mask & conn)) == '0));

    p_disc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pins ^ $past(pins)) & ~$past(conn)) == '0));

    if (!HAS_MASTER) begin : g_nomaster
        p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (addr == A_MASK || addr == A_DATA) |-> (rdata == '0));
        p_no_master_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !ev7);
    end
endmodule

bind timer_oc timer_oc_chk #(.CNT_W(CNT_W), .HAS_MASTER(HAS_MASTER)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tmr_en (tmr_en),
    .cnt    (cnt_w),
    .match  (match_w),
    .ovf    (ovf_w),
    .ev7    (ev7_w),
    .conn   (conn_w),
    .cfg    (cfg_w),
    .addr   (bus_addr),
    .rdata  (bus_rdata),
    .pins   (oc_pin)
);

// File: tb/timer_oc_test.sv
`timescale 1ns/1ps
module timer_oc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_rdata, rdata_nm;
    logic [7:0]  oc_pin, pin_nm;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    timer_oc uut (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .oc_pin(oc_pin)
    );

    timer_oc #(.HAS_MASTER(1'b0)) uut_nm (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rdata(rdata_nm), .oc_pin(pin_nm)
    );

    // {addr, write data, expected read-back}
    localparam logic [35:0] VEC [10] = '{
        {4'h0, 16'h1234, 16'h1234},
        {4'h7, 16'hFFFF, 16'hFFFF},
        {4'h8, 16'h01FF, 16'h00FF},
        {4'h9, 16'hAB5A, 16'h005A},
        {4'hA, 16'h0081, 16'h0081},
        {4'hB, 16'h013C, 16'h003C},
        {4'hC, 16'h00C3, 16'h00C3},
        {4'hD, 16'hFFE4, 16'h00E4},
        {4'hE, 16'h00FF, 16'h003F},
        {4'hF, 16'h1234, 16'h0000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v, output logic [15:0] vnm);
        @(negedge clk);
        bus_addr = a;
        #1;
        v   = bus_rdata;
        vnm = rdata_nm;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tmr_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tmr_en = 1'b0;
    endtask

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, vnm;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        chk("R12 pins", {8'h00, oc_pin}, 16'h0000);
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], v, vnm);
            chk("R12 reg", v, 16'h0000);
        end

        // R10 / R11: register table
        for (int k = 0; k < 10; k++) begin
            wr(VEC[k][35:32], VEC[k][31:16]);
            rd(VEC[k][35:32], v, vnm);
            chk("R10 readback", v, VEC[k][15:0]);
            if (VEC[k][35:32] == 4'hB || VEC[k][35:32] == 4'hC)
                chk("R11 reserved", vnm, 16'h0000);
        end
        for (int a = 0; a < 15; a++) wr(a[3:0], 16'h0000);
        chk("R9 bus writes leave pins", {8'h00, oc_pin}, 16'h0000);

        // R2 / R3: actions (ch0 toggle, ch1 clear, ch2 set, ch3 none)
        wr(4'h8, 16'h00FF);
        wr(4'hD, 16'h0039);
        for (int c = 0; c < 4; c++) wr(c[3:0], 16'd5);
        tick(4);
        chk("R2 no early match", {8'h00, oc_pin}, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R1 counter holds while disabled", {8'h00, oc_pin}, 16'h0000);
        tick(1);
        chk("R3 action codes", {8'h00, oc_pin}, 16'h0005);

        // R5 / R6 / R7 / R8: master event collides with ch0 toggle and ch3 set
        wr(4'hB, 16'h0081);
        wr(4'hC, 16'h0081);
        wr(4'hD, 16'h00F9);
        wr(4'h0, 16'd8);
        wr(4'h3, 16'd8);
        wr(4'h7, 16'd8);
        tick(2);
        chk("R2 before match", {8'h00, oc_pin}, 16'h0005);
        tick(1);
        chk("R8 override beats toggle, R7 unmasked set, R6 pin7", {8'h00, oc_pin}, 16'h008D);
        chk("R11 no master event", {8'h00, pin_nm}, 16'h000C);

        // R9: disconnected pin 3 and unselected pin 2 hold
        wr(4'h9, 16'h0008);
        wr(4'h8, 16'h00FB);
        wr(4'hB, 16'h0009);
        wr(4'hC, 16'h0000);
        wr(4'hD, 16'h00E9);
        wr(4'h2, 16'd10);
        wr(4'h7, 16'd10);
        tick(2);
        chk("R9 gated pins hold, R6 pin0 cleared", {8'h00, oc_pin}, 16'h008C);

        // R1 / R4 / R5: overflow
        wr(4'h9, 16'h0000);
        wr(4'h8, 16'h00FF);
        wr(4'hA, 16'h008A);
        wr(4'hB, 16'h0080);
        wr(4'hC, 16'h0000);
        wr(4'h3, 16'd0);
        wr(4'h7, 16'd5);
        tick(65525);
        chk("R4 nothing before wrap", {8'h00, oc_pin}, 16'h008C);
        tick(1);
        chk("R4 toggle, compare wins, R5 overflow event", {8'h00, oc_pin}, 16'h000E);
        tick(5);
        chk("R1 wrapped count reaches 5", {8'h00, oc_pin}, 16'h000C);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule